// File: doc/BRIEF.md
# Instruction-Decoded Integer ALU

This block is the combinational arithmetic and logic unit of a small 32-bit core that uses three instruction formats. It takes the raw 6-bit opcode and 6-bit function field of an instruction and works out for itself which operation to perform. Its inputs are two register operands, the 16-bit immediate field and the 5-bit shift-amount field. Its outputs are a 32-bit result and a signed-overflow flag, which the core uses to raise a trap.

The decoder sets four things for each operation: whether the second operand is the register or the immediate, whether the immediate is sign-extended or zero-extended, whether a shift count comes from the instruction or from a register, and whether the operation can trap on overflow. Add and subtract come in two forms that give the same result: the trapping form and the non-trapping form. Only the trapping form can raise the overflow flag. The register file, memory access, branches and multiply/divide belong to other blocks.

Top module: `int_alu`

## Requirements
- R1: With opcode 0, funct 32 gives a+b, 34 gives a-b, 36 gives a&b, 37 gives a|b, 38 gives a^b and 39 gives ~(a|b), where a is `src_a` and b is `src_b`.
- R2: Set-less-than (opcode 0 with funct 42, comparing against `src_b`; opcode 10, comparing against the sign-extended immediate) compares signed two's-complement values and gives 1 or 0 in bit 0, with all other bits zero.
- R3: Trapping add (opcode 0 funct 32), trapping subtract (opcode 0 funct 34) and add-immediate (opcode 8) raise `ovf` exactly when the true signed result does not fit in 32 bits; `result` still carries the wrapped value.
- R4: Non-trapping add (funct 33), non-trapping subtract (funct 35) and non-trapping add-immediate (opcode 9) give the wrapped sum or difference and never raise `ovf`.
- R5: Opcodes 8, 9 and 10 sign-extend the 16-bit immediate (bit 15 copied into bits 31..16).
- R6: Opcodes 12 (and), 13 (or) and 14 (xor) combine `src_a` with the zero-extended immediate.
- R7: Opcode 15 gives the immediate in bits 31..16 and zero in bits 15..0, whatever the value of `src_a`.
- R8: With opcode 0, funct 0, 2 and 3 shift `src_b` left, logically right and arithmetically right by `shamt`.
- R9: With opcode 0, funct 4, 6 and 7 shift `src_b` left, logically right and arithmetically right by `src_a[4:0]`; bits 31..5 of `src_a` have no effect.
- R10: Arithmetic right shifts fill the vacated upper bits with bit 31 of `src_b`; logical shifts fill them with zero.
- R11: Any opcode or function code not listed above gives a result of zero and `ovf` low.
- R12: `ovf` is low for every operation other than the three trapping ones of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary operation code of the instruction |
| funct | input | 6 | Function field, decoded when opcode is 0 |
| src_a | input | 32 | First register operand; also the count for variable shifts |
| src_b | input | 32 | Second register operand; also the value being shifted |
| imm | input | 16 | Immediate field of the instruction |
| shamt | input | 5 | Shift-amount field of the instruction |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
The wrapped adder output and the overflow detector are produced in the same evaluation. They must agree: when `ovf` is high, `result` must still hold the wrapped value, and the non-trapping twin must give the same bits with the flag low. The bench provokes this case with operand pairs at the signed extremes (0x7fffffff, 0x80000000, 0xffffffff, 0x00008000). It sweeps every opcode and every function code over these pairs and over pseudo-random pairs, and judges both outputs against a reference model that finds overflow from a 33-bit sum rather than from sign rules.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W  = 32;
    localparam int IMM_W   = 16;
    localparam int SHW     = $clog2(DATA_W);
    localparam int CODE_W  = 6;

    // primary opcodes
    localparam logic [CODE_W-1:0] OPC_REG   = 6'd0;
    localparam logic [CODE_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [CODE_W-1:0] OPC_ADDIU = 6'd9;
    localparam logic [CODE_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [CODE_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [CODE_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [CODE_W-1:0] OPC_XORI  = 6'd14;
    localparam logic [CODE_W-1:0] OPC_LUI   = 6'd15;

    // function codes under OPC_REG
    localparam logic [CODE_W-1:0] FC_SLL  = 6'd0;
    localparam logic [CODE_W-1:0] FC_SRL  = 6'd2;
    localparam logic [CODE_W-1:0] FC_SRA  = 6'd3;
    localparam logic [CODE_W-1:0] FC_SLLV = 6'd4;
    localparam logic [CODE_W-1:0] FC_SRLV = 6'd6;
    localparam logic [CODE_W-1:0] FC_SRAV = 6'd7;
    localparam logic [CODE_W-1:0] FC_ADD  = 6'd32;
    localparam logic [CODE_W-1:0] FC_ADDU = 6'd33;
    localparam logic [CODE_W-1:0] FC_SUB  = 6'd34;
    localparam logic [CODE_W-1:0] FC_SUBU = 6'd35;
    localparam logic [CODE_W-1:0] FC_AND  = 6'd36;
    localparam logic [CODE_W-1:0] FC_OR   = 6'd37;
    localparam logic [CODE_W-1:0] FC_XOR  = 6'd38;
    localparam logic [CODE_W-1:0] FC_NOR  = 6'd39;
    localparam logic [CODE_W-1:0] FC_SLT  = 6'd42;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_SLT, K_LUI, K_SHL, K_SHR, K_SAR
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      use_imm;    // second operand is the immediate
        logic      imm_signed; // sign-extend rather than zero-extend
        logic      var_shift;  // shift count taken from src_a
        logic      can_trap;   // overflow flag enabled
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_ctrl(input logic [CODE_W-1:0] opc,
                                              input logic [CODE_W-1:0] fc);
        alu_ctrl_t c;
        c = '{kind: K_NONE, use_imm: 1'b0, imm_signed: 1'b0,
              var_shift: 1'b0, can_trap: 1'b0};
        unique case (opc)
            OPC_REG: begin
                unique case (fc)
                    FC_ADD:  begin c.kind = K_ADD; c.can_trap = 1'b1; end
                    FC_ADDU: c.kind = K_ADD;
                    FC_SUB:  begin c.kind = K_SUB; c.can_trap = 1'b1; end
                    FC_SUBU: c.kind = K_SUB;
                    FC_AND:  c.kind = K_AND;
                    FC_OR:   c.kind = K_OR;
                    FC_XOR:  c.kind = K_XOR;
                    FC_NOR:  c.kind = K_NOR;
                    FC_SLT:  c.kind = K_SLT;
                    FC_SLL:  c.kind = K_SHL;
                    FC_SRL:  c.kind = K_SHR;
                    FC_SRA:  c.kind = K_SAR;
                    FC_SLLV: begin c.kind = K_SHL; c.var_shift = 1'b1; end
                    FC_SRLV: begin c.kind = K_SHR; c.var_shift = 1'b1; end
                    FC_SRAV: begin c.kind = K_SAR; c.var_shift = 1'b1; end
                    default: c.kind = K_NONE;
                endcase
            end
            OPC_ADDI: begin
                c.kind = K_ADD; c.use_imm = 1'b1; c.imm_signed = 1'b1;
                c.can_trap = 1'b1;
            end
            OPC_ADDIU: begin
                c.kind = K_ADD; c.use_imm = 1'b1; c.imm_signed = 1'b1;
            end
            OPC_SLTI: begin
                c.kind = K_SLT; c.use_imm = 1'b1; c.imm_signed = 1'b1;
            end
            OPC_ANDI: begin c.kind = K_AND; c.use_imm = 1'b1; end
            OPC_ORI:  begin c.kind = K_OR;  c.use_imm = 1'b1; end
            OPC_XORI: begin c.kind = K_XOR; c.use_imm = 1'b1; end
            OPC_LUI:  begin c.kind = K_LUI; c.use_imm = 1'b1; end
            default:  c.kind = K_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [CODE_W-1:0] opcode,
    input  logic [CODE_W-1:0] funct,
    output alu_ctrl_t         ctrl
);
    always_comb ctrl = decode_ctrl(opcode, funct);
endmodule

// File: rtl/alu_operand.sv
module alu_operand
    import alu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int IW  = IMM_W,
    parameter int SW  = SHW
) (
    input  alu_ctrl_t        ctrl,
    input  logic [W-1:0]     src_b,
    input  logic [IW-1:0]    imm,
    input  logic [SW-1:0]    shamt,
    input  logic [SW-1:0]    reg_count,
    output logic [W-1:0]     opnd_b,
    output logic [SW-1:0]    count
);
    localparam int EXT = W - IW;

    logic [W-1:0] imm_ext;

    always_comb begin
        imm_ext = ctrl.imm_signed ? {{EXT{imm[IW-1]}}, imm} : {{EXT{1'b0}}, imm};
        opnd_b  = ctrl.use_imm ? imm_ext : src_b;
        count   = ctrl.var_shift ? reg_count : shamt;
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] cnt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [0:SW];
    logic         fill;
    logic [W-1:0] rev_in;
    logic [W-1:0] last;

    // left shifts reuse the right-shift network on a bit-reversed word
    always_comb begin
        for (int i = 0; i < W; i++) rev_in[i] = din[W-1-i];
        stage[0] = left ? rev_in : din;
        fill     = arith & ~left & din[W-1];
    end

    generate
        for (genvar s = 0; s < SW; s++) begin : g_stage
            localparam int AMT = 1 << s;
            always_comb begin
                if (cnt[s])
                    stage[s+1] = {{AMT{fill}}, stage[s][W-1:AMT]};
                else
                    stage[s+1] = stage[s];
            end
        end
    endgenerate

    always_comb begin
        last = stage[SW];
        for (int i = 0; i < W; i++) dout[i] = left ? last[W-1-i] : last[i];
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
(
    input  logic [5:0]  opcode,
    input  logic [5:0]  funct,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [15:0] imm,
    input  logic [4:0]  shamt,
    output logic [31:0] result,
    output logic        ovf
);
    localparam int W   = DATA_W;
    localparam int LUI_SH = W - IMM_W;

    alu_ctrl_t    ctrl;
    logic [W-1:0] opnd_b;
    logic [SHW-1:0] count;
    logic [W-1:0] shifted;
    logic [W-1:0] addend;
    logic [W-1:0] sum;
    logic         is_sub;
    logic         less;

    alu_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    alu_operand #(.W(W), .IW(IMM_W), .SW(SHW)) u_opnd (
        .ctrl      (ctrl),
        .src_b     (src_b),
        .imm       (imm),
        .shamt     (shamt),
        .reg_count (src_a[SHW-1:0]),
        .opnd_b    (opnd_b),
        .count     (count)
    );

    alu_shifter #(.W(W), .SW(SHW)) u_shf (
        .din   (src_b),
        .cnt   (count),
        .left  (ctrl.kind == K_SHL),
        .arith (ctrl.kind == K_SAR),
        .dout  (shifted)
    );

    // single adder serves add and subtract
    always_comb begin
        is_sub = (ctrl.kind == K_SUB);
        addend = is_sub ? ~opnd_b : opnd_b;
        sum    = src_a + addend + {{(W-1){1'b0}}, is_sub};
        less   = $signed(src_a) < $signed(opnd_b);
    end

    always_comb begin
        unique case (ctrl.kind)
            K_ADD, K_SUB: result = sum;
            K_AND:        result = src_a & opnd_b;
            K_OR:         result = src_a | opnd_b;
            K_XOR:        result = src_a ^ opnd_b;
            K_NOR:        result = ~(src_a | opnd_b);
            K_SLT:        result = {{(W-1){1'b0}}, less};
            K_LUI:        result = opnd_b << LUI_SH;
            K_SHL, K_SHR, K_SAR: result = shifted;
            default:      result = '0;
        endcase
        ovf = ctrl.can_trap & (src_a[W-1] == addend[W-1]) & (sum[W-1] != src_a[W-1]);
    end
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker (
    input logic [5:0]  opcode,
    input logic [5:0]  funct,
    input logic [31:0] src_b,
    input logic [15:0] imm,
    input logic [31:0] result,
    input logic        ovf
);
    logic known;
    logic is_r;
    logic trap_op;
    logic nontrap_add;
    logic slt_op;
    logic legal;

    always_comb begin
        known = !$isunknown({opcode, funct, src_b, imm, result, ovf});
        is_r  = (opcode == 6'd0);
        trap_op = (is_r && (funct == 6'd32 || funct == 6'd34)) || opcode == 6'd8;
        nontrap_add = (is_r && (funct == 6'd33 || funct == 6'd35)) || opcode == 6'd9;
        slt_op = (is_r && funct == 6'd42) || opcode == 6'd10;
        legal = is_r ? (funct inside {6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7,
                                     [6'd32:6'd39], 6'd42})
                     : (opcode inside {[6'd8:6'd10], [6'd12:6'd15]});
    end

    always_comb begin
        if (known) begin
            // R4
            p_no_overflow_r4: assert (!nontrap_add || !ovf)
                else $error("non-trapping add/sub raised overflow");
            // R12
            p_ovf_trap_only_r12: assert (trap_op || !ovf)
                else $error("overflow on a non-trapping operation");
            // R2
            p_slt_boolean_r2: assert (!slt_op || result[31:1] == 31'd0)
                else $error("set-less-than produced a non-boolean");
            // R7
            p_lui_place_r7: assert (opcode != 6'd15 || result == {imm, 16'h0000})
                else $error("upper-immediate load misplaced");
            // R11
            p_illegal_quiet_r11: assert (legal || (result == 32'd0 && !ovf))
                else $error("undefined code produced output");
            // R10
            p_sra_sign_r10: assert (!(is_r && (funct == 6'd3 || funct == 6'd7))
                                    || result[31] == src_b[31])
                else $error("arithmetic shift lost the sign");
        end
    end
endmodule

bind int_alu int_alu_checker u_chk (
    .opcode (opcode),
    .funct  (funct),
    .src_b  (src_b),
    .imm    (imm),
    .result (result),
    .ovf    (ovf)
);

// File: tb/int_alu_test.sv
module int_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct  = '0;
    logic [31:0] src_a  = '0;
    logic [31:0] src_b  = '0;
    logic [15:0] imm    = '0;
    logic [4:0]  shamt  = '0;
    logic [31:0] result;
    logic        ovf;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    int_alu uut (
        .opcode (opcode), .funct (funct), .src_a (src_a), .src_b (src_b),
        .imm (imm), .shamt (shamt), .result (result), .ovf (ovf)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
        if (op == 0) begin
            case (fn)
                6'd32, 6'd34: return "R3";
                6'd33, 6'd35: return "R4";
                6'd36, 6'd37, 6'd38, 6'd39: return "R1";
                6'd42: return "R2";
                6'd0, 6'd2: return "R8";
                6'd3: return "R10";
                6'd4, 6'd6, 6'd7: return "R9";
                default: return "R11";
            endcase
        end
        case (op)
            6'd8: return "R3";
            6'd9: return "R5";
            6'd10: return "R2";
            6'd12, 6'd13, 6'd14: return "R6";
            6'd15: return "R7";
            default: return "R11";
        endcase
    endfunction

    // behavioural reference: overflow from a 33-bit sum
    task automatic model(input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh,
                         output logic [31:0] r, output logic o);
        logic [32:0] wide;
        logic [31:0] se, ze;
        se = 32'(signed'(im));
        ze = {16'h0, im};
        r = '0; o = 1'b0;
        if (op == 0) begin
            case (fn)
                6'd32: begin wide = {a[31], a} + {b[31], b}; r = wide[31:0]; o = wide[32] ^ wide[31]; end
                6'd33: r = a + b;
                6'd34: begin wide = {a[31], a} - {b[31], b}; r = wide[31:0]; o = wide[32] ^ wide[31]; end
                6'd35: r = a - b;
                6'd36: r = a & b;
                6'd37: r = a | b;
                6'd38: r = a ^ b;
                6'd39: r = ~(a | b);
                6'd42: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                6'd0:  r = b << sh;
                6'd2:  r = b >> sh;
                6'd3:  r = $signed(b) >>> sh;
                6'd4:  r = b << a[4:0];
                6'd6:  r = b >> a[4:0];
                6'd7:  r = $signed(b) >>> a[4:0];
                default: r = '0;
            endcase
        end else begin
            case (op)
                6'd8:  begin wide = {a[31], a} + {se[31], se}; r = wide[31:0]; o = wide[32] ^ wide[31]; end
                6'd9:  r = a + se;
                6'd10: r = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
                6'd12: r = a & ze;
                6'd13: r = a | ze;
                6'd14: r = a ^ ze;
                6'd15: r = {im, 16'h0};
                default: r = '0;
            endcase
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh,
                         input string tag);
        logic [31:0] er;
        logic        eo;
        @(posedge clk);
        #1;
        opcode = op; funct = fn; src_a = a; src_b = b; imm = im; shamt = sh;
        model(op, fn, a, b, im, sh, er, eo);
        @(negedge clk);
        n_checks++;
        if (result !== er || ovf !== eo) begin
            n_fail++;
            $display("FAIL %s op=%0d fn=%0d a=%h b=%h imm=%h sh=%0d: got %h/%b expected %h/%b",
                     tag, op, fn, a, b, im, sh, result, ovf, er, eo);
        end
    endtask

    // directed check with an explicitly stated expectation
    task automatic expect_eq(input logic [5:0] op, input logic [5:0] fn,
                             input logic [31:0] a, input logic [31:0] b,
                             input logic [15:0] im, input logic [4:0] sh,
                             input logic [31:0] er, input logic eo, input string tag);
        @(posedge clk);
        #1;
        opcode = op; funct = fn; src_a = a; src_b = b; imm = im; shamt = sh;
        @(negedge clk);
        n_checks++;
        if (result !== er || ovf !== eo) begin
            n_fail++;
            $display("FAIL %s directed op=%0d fn=%0d: got %h/%b expected %h/%b",
                     tag, op, fn, result, ovf, er, eo);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] corner [0:6];
        logic [31:0] lfsr;
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'h7fff_ffff; corner[3] = 32'h8000_0000;
        corner[4] = 32'hffff_ffff; corner[5] = 32'h0000_ffff;
        corner[6] = 32'h0000_8000;
        lfsr = 32'hace1_2468;

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset/idle state: all-zero inputs decode to a zero shift of zero (R8)
        expect_eq(6'd0, 6'd0, 32'd0, 32'd0, 16'd0, 5'd0, 32'd0, 1'b0, "R8");

        // directed corners
        expect_eq(6'd0, 6'd32, 32'h7fff_ffff, 32'd1, 16'd0, 5'd0, 32'h8000_0000, 1'b1, "R3");
        expect_eq(6'd0, 6'd33, 32'h7fff_ffff, 32'd1, 16'd0, 5'd0, 32'h8000_0000, 1'b0, "R4");
        expect_eq(6'd0, 6'd34, 32'd0, 32'h8000_0000, 16'd0, 5'd0, 32'h8000_0000, 1'b1, "R3");
        expect_eq(6'd0, 6'd35, 32'd0, 32'h8000_0000, 16'd0, 5'd0, 32'h8000_0000, 1'b0, "R4");
        expect_eq(6'd8, 6'd0, 32'h8000_0000, 32'd0, 16'hffff, 5'd0, 32'h7fff_ffff, 1'b1, "R3");
        expect_eq(6'd9, 6'd0, 32'd5, 32'd0, 16'hfffe, 5'd0, 32'd3, 1'b0, "R5");
        expect_eq(6'd10, 6'd0, 32'hffff_fff0, 32'd0, 16'hffff, 5'd0, 32'd1, 1'b0, "R2");
        expect_eq(6'd0, 6'd42, 32'd1, 32'hffff_ffff, 16'd0, 5'd0, 32'd0, 1'b0, "R2");
        expect_eq(6'd12, 6'd0, 32'hffff_ffff, 32'd0, 16'h8001, 5'd0, 32'h0000_8001, 1'b0, "R6");
        expect_eq(6'd15, 6'd0, 32'hdead_beef, 32'd0, 16'h2110, 5'd0, 32'h2110_0000, 1'b0, "R7");
        expect_eq(6'd0, 6'd7, 32'hffff_ffe4, 32'h8000_0000, 16'd0, 5'd0, 32'hf800_0000, 1'b0, "R9");
        expect_eq(6'd0, 6'd6, 32'h0000_0024, 32'h8000_0000, 16'd0, 5'd31, 32'h0800_0000, 1'b0, "R9");
        expect_eq(6'd0, 6'd3, 32'd0, 32'h8000_0000, 16'd0, 5'd31, 32'hffff_ffff, 1'b0, "R10");
        expect_eq(6'd0, 6'd2, 32'd0, 32'h8000_0000, 16'd0, 5'd31, 32'h0000_0001, 1'b0, "R10");
        expect_eq(6'd0, 6'd39, 32'd0, 32'd0, 16'd0, 5'd0, 32'hffff_ffff, 1'b0, "R1");
        expect_eq(6'd0, 6'd40, 32'h7fff_ffff, 32'd1, 16'd0, 5'd0, 32'd0, 1'b0, "R11");
        expect_eq(6'd11, 6'd32, 32'h7fff_ffff, 32'd1, 16'hffff, 5'd0, 32'd0, 1'b0, "R11");

        // sweep: every code, corner and pseudo-random operands (R1..R12)
        for (int op = 0; op < 64; op++) begin
            for (int fn = 0; fn < 64; fn++) begin
                if (op != 0 && fn > 1) continue;
                for (int k = 0; k < 20; k++) begin
                    logic [31:0] a, b;
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    a = (k < 7) ? corner[k] : lfsr;
                    b = (k < 14) ? corner[(k * 3) % 7] : {lfsr[15:0], lfsr[31:16]};
                    apply(6'(op), 6'(fn), a, b,
                          (k % 3 == 0) ? corner[k % 7][15:0] : lfsr[23:8],
                          5'(k + lfsr[2:0]), tag_of(6'(op), 6'(fn)));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule